// File: doc/BRIEF.md
# Serial Register Port Host

This block drives a three-wire synchronous control port of a byte-addressed register bank from a simple parallel request interface. The port has a frame strobe held low while a frame is sent, a serial clock and a serial data line. A second input carries the read-back bit stream. A request gives the operation, a 4-bit register address and, for writes, a data byte. The host then produces the whole pin sequence and raises `busy_o` until the strobe has returned high.

A write is a single 18-pulse frame. A read is a 27-pulse transaction. It starts with an 18-pulse header. One isolated pulse follows with the strobe high, then an 8-pulse window in which the returned byte is sampled. The serial clock period is a whole number of system clocks and is set by an input. The strobe and data line change only in the middle of the clock-low phase, so setup and hold hold by a full system cycle at the shortest period.

Top module: `serial_port_host`

## Requirements
- R1: After reset the strobe `ser_en_o` is 1, `ser_clk_o` and `ser_dat_o` are 0, and `busy_o` and `rd_valid_o` are 0.
- R2: A write (`rd_i`=0) gives exactly 18 clock pulses with the strobe low. At pulse k the data line carries bit k of the word {3'b111, 1'b1, 2'b00, addr[3:0], wdata[7:0]}, bit 0 first. The strobe then returns high and no further pulse follows.
- R3: `ser_en_o` and `ser_dat_o` change only while `ser_clk_o` is low. They never change in the system cycle in which the serial clock rises or the cycle in which it falls. This gives at least one system cycle of setup, hold and clock-low time before the strobe rises.
- R4: A read (`rd_i`=1) gives 27 pulses. Pulses 0..17 carry {3'b111, 1'b0, 2'b00, addr[3:0], 8'h00}, bit 0 first, with the strobe low. Pulse 18 has the strobe high. Pulses 19..26 have the strobe low. The strobe then returns high.
- R5: During read pulses 18 through 26 the data line is 0.
- R6: On a read, the bit on `ser_din_i` during read pulse 19+j becomes bit j of `rd_data_o`. The line is sampled in the last system cycle of that pulse's high phase. `rd_valid_o` is high for exactly one cycle, when the strobe returns high, with `rd_data_o` valid in that cycle.
- R7: The serial period is max(`period_i`, 4) system clocks, and the clock is high for floor(period/2) of them. The period is latched while the host is idle.
- R8: `busy_o` is high from the cycle after an accepted `start_i` until the strobe returns high. A `start_i` while busy is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | DIV_W | Serial clock period in system clocks (floor 4) |
| start_i | input | 1 | Request strobe, taken when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Transaction in progress |
| rd_valid_o | output | 1 | One-cycle read-data strobe |
| rd_data_o | output | 8 | Byte returned by a read |
| ser_en_o | output | 1 | Frame strobe, low during a frame |
| ser_clk_o | output | 1 | Serial clock |
| ser_dat_o | output | 1 | Serial data out |
| ser_din_i | input | 1 | Serial read-back data |

## Verification
The assertions on the timer phase bound assume `period_i` is only relied on while idle. The bench changes it only between transactions. The read-data checks assume the register bank changes `ser_din_i` right after a rising serial clock edge and holds it for the high phase. The bench's port model drives the line at the detected rising edge, so each bit is stable well before the sampling cycle. Requests are issued as one-cycle strobes, and a start while busy is issued on purpose only in the test that covers it.

// File: rtl/sph_pkg.sv
package sph_pkg;
  localparam int HDR_BITS    = 18;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 4;
  localparam int ADDR_FIELD  = 6;
  localparam int MIN_PERIOD  = 4;
  localparam int SLOT_W      = 5;
  localparam int WR_LAST     = HDR_BITS;
  localparam int GAP_SLOT    = HDR_BITS;
  localparam int WIN_FIRST   = HDR_BITS + 1;
  localparam int WIN_LAST    = HDR_BITS + DATA_W;
  localparam int RD_LAST     = WIN_LAST + 1;
  localparam logic [2:0] PORT_ID = 3'b111;

  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;
endpackage

// File: rtl/sph_sclk_timer.sv
module sph_sclk_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] period_i,
  output logic             mid_o,
  output logic             rise_o,
  output logic             end_o
);
  import sph_pkg::*;

  logic [DIV_W-1:0] per_q, per_d, cnt_q, cnt_d;
  logic [DIV_W-1:0] per_clamp, low_len, mid_pt;

  assign per_clamp = (period_i < DIV_W'(MIN_PERIOD)) ? DIV_W'(MIN_PERIOD) : period_i;
  assign low_len   = per_q - (per_q >> 1);
  assign mid_pt    = (low_len - DIV_W'(1)) >> 1;

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q;
    if (!run_i) begin
      per_d = per_clamp;
      cnt_d = '0;
    end else if (cnt_q == per_q - DIV_W'(1)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= DIV_W'(MIN_PERIOD);
      cnt_q <= '0;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
    end
  end

  assign mid_o  = run_i && (cnt_q == mid_pt);
  assign rise_o = run_i && (cnt_q == low_len - DIV_W'(1));
  assign end_o  = run_i && (cnt_q == per_q - DIV_W'(1));

  assert_phase_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < per_q));
  assert_period_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q >= DIV_W'(MIN_PERIOD));
endmodule

// File: rtl/sph_capture.sv
module sph_capture #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o
);
  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_i) sr_d = {bit_i, sr_q[W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign byte_o = sr_q;
endmodule

// File: rtl/sph_frame_seq.sv
module sph_frame_seq (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      rd_i,
  input  logic [sph_pkg::ADDR_W-1:0] addr_i,
  input  logic [sph_pkg::DATA_W-1:0] wdata_i,
  input  logic                      mid_i,
  input  logic                      rise_i,
  input  logic                      end_i,
  output logic                      run_o,
  output logic                      sck_o,
  output logic                      en_o,
  output logic                      sdo_o,
  output logic                      shift_o,
  output logic                      rdv_o
);
  import sph_pkg::*;

  seq_state_e          state_q, state_d;
  logic                rd_q, rd_d;
  logic [HDR_BITS-1:0] frame_q, frame_d;
  logic [SLOT_W-1:0]   slot_q, slot_d, last;
  logic                sck_q, sck_d, en_q, en_d, sdo_q, sdo_d, rdv_q, rdv_d;
  logic                in_hdr, slot_en, slot_dat, slot_pls, cap_slot;

  assign last     = rd_q ? SLOT_W'(RD_LAST) : SLOT_W'(WR_LAST);
  assign in_hdr   = slot_q < SLOT_W'(HDR_BITS);
  assign slot_en  = in_hdr ? 1'b0 :
                    ((slot_q == last) || (rd_q && slot_q == SLOT_W'(GAP_SLOT)));
  assign slot_dat = in_hdr ? frame_q[slot_q] : 1'b0;
  assign slot_pls = (slot_q != last);
  assign cap_slot = rd_q && (slot_q >= SLOT_W'(WIN_FIRST)) && (slot_q <= SLOT_W'(WIN_LAST));

  always_comb begin
    state_d = state_q;
    rd_d    = rd_q;
    frame_d = frame_q;
    slot_d  = slot_q;
    sck_d   = sck_q;
    en_d    = en_q;
    sdo_d   = sdo_q;
    rdv_d   = 1'b0;
    if (state_q == SEQ_IDLE) begin
      en_d  = 1'b1;
      sck_d = 1'b0;
      sdo_d = 1'b0;
      if (start_i) begin
        state_d = SEQ_RUN;
        rd_d    = rd_i;
        slot_d  = '0;
        frame_d = {PORT_ID, ~rd_i, {(ADDR_FIELD-ADDR_W){1'b0}}, addr_i,
                   rd_i ? {DATA_W{1'b0}} : wdata_i};
      end
    end else begin
      if (mid_i) begin
        en_d  = slot_en;
        sdo_d = slot_dat;
        if (slot_q == last) begin
          state_d = SEQ_IDLE;
          rdv_d   = rd_q;
        end
      end
      if (rise_i) sck_d = slot_pls;
      if (end_i) begin
        sck_d  = 1'b0;
        slot_d = slot_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      rd_q    <= 1'b0;
      frame_q <= '0;
      slot_q  <= '0;
      sck_q   <= 1'b0;
      en_q    <= 1'b1;
      sdo_q   <= 1'b0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rd_q    <= rd_d;
      frame_q <= frame_d;
      slot_q  <= slot_d;
      sck_q   <= sck_d;
      en_q    <= en_d;
      sdo_q   <= sdo_d;
      rdv_q   <= rdv_d;
    end
  end

  assign run_o   = (state_q == SEQ_RUN);
  assign sck_o   = sck_q;
  assign en_o    = en_q;
  assign sdo_o   = sdo_q;
  assign shift_o = run_o && end_i && cap_slot;
  assign rdv_o   = rdv_q;

  assert_en_moves_clk_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> (!sck_q && !$past(sck_q)));
  assert_dat_moves_clk_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_q) |-> (!sck_q && !$past(sck_q)));
  assert_tail_dat_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && rd_q && sck_q && slot_q >= SLOT_W'(GAP_SLOT)) |-> !sdo_q);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE) |-> (!sck_q && en_q));
  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdv_q |=> !rdv_q);
endmodule

// File: rtl/serial_port_host.sv
module serial_port_host #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] period_i,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [3:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic             busy_o,
  output logic             rd_valid_o,
  output logic [7:0]       rd_data_o,
  output logic             ser_en_o,
  output logic             ser_clk_o,
  output logic             ser_dat_o,
  input  logic             ser_din_i
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       run, mid, rise, fin, shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  sph_sclk_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .period_i(period_i),
    .mid_o(mid), .rise_o(rise), .end_o(fin)
  );

  sph_frame_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_n), .start_i(start_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .mid_i(mid), .rise_i(rise), .end_i(fin),
    .run_o(run), .sck_o(ser_clk_o), .en_o(ser_en_o), .sdo_o(ser_dat_o),
    .shift_o(shift), .rdv_o(rd_valid_o)
  );

  sph_capture #(.W(8)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_n), .shift_i(shift), .bit_i(ser_din_i),
    .byte_o(rd_data_o)
  );

  assign busy_o = run;

  assert_no_pulse_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy_o |-> !ser_clk_o);
endmodule

// File: tb/serial_port_host_tb_top.sv
module serial_port_host_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] period = 8'd4;
  logic       start = 1'b0, rd = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [7:0] wdata = 8'd0;
  logic       busy, rd_valid, sen, sck, sdo;
  logic [7:0] rd_data;
  logic       din = 1'b0;

  int errors = 0, checks = 0;
  int cyc = 0;
  int pc = 0;
  logic en_at [0:31];
  logic dat_at [0:31];
  logic [7:0] dev_byte = 8'h00;
  int viol = 0;
  int last_rise = -1, per_min = 1000, per_max = 0, hi_len = 0, hi_min = 1000, hi_max = 0;
  int rdv_count = 0;
  logic [7:0] rdv_data = 8'h00;
  logic p_sck = 1'b0, p_en = 1'b1, p_sdo = 1'b0;

  always #5 clk = ~clk;

  serial_port_host #(.DIV_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .period_i(period), .start_i(start), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .rd_valid_o(rd_valid),
    .rd_data_o(rd_data), .ser_en_o(sen), .ser_clk_o(sck), .ser_dat_o(sdo),
    .ser_din_i(din)
  );

  // port model and pin monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if ((sck || p_sck) && (sen !== p_en || sdo !== p_sdo)) viol = viol + 1;
    if (sck && !p_sck) begin
      if (pc < 32) begin en_at[pc] = sen; dat_at[pc] = sdo; end
      if (last_rise >= 0) begin
        if (cyc - last_rise < per_min) per_min = cyc - last_rise;
        if (cyc - last_rise > per_max) per_max = cyc - last_rise;
      end
      last_rise = cyc;
      if (pc >= 19 && pc <= 26) din = dev_byte[pc-19];
      pc = pc + 1;
    end
    if (sck) hi_len = hi_len + 1;
    if (!sck && p_sck) begin
      if (hi_len < hi_min) hi_min = hi_len;
      if (hi_len > hi_max) hi_max = hi_len;
      hi_len = 0;
    end
    if (rd_valid) begin rdv_count = rdv_count + 1; rdv_data = rd_data; end
    p_sck = sck; p_en = sen; p_sdo = sdo;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    pc = 0; last_rise = -1; per_min = 1000; per_max = 0;
    hi_min = 1000; hi_max = 0; rdv_count = 0; viol = 0;
  endtask

  task automatic issue(input bit r, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    start = 1'b1; rd = r; addr = a; wdata = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) check(1'b0, "watchdog", n, 0);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [17:0] hdr(input bit r, input logic [3:0] a, input logic [7:0] d);
    return {3'b111, ~r, 2'b00, a, r ? 8'h00 : d};
  endfunction

  task automatic t_reset();
    check(sen === 1'b1 && sck === 1'b0 && sdo === 1'b0, "R1 pins", {sen, sck, sdo}, 3'b100);
    check(busy === 1'b0 && rd_valid === 1'b0, "R1 status", {busy, rd_valid}, 0);
  endtask

  task automatic t_write(input logic [3:0] a, input logic [7:0] d, input logic [7:0] per);
    logic [17:0] e = hdr(1'b0, a, d);
    int bad = 0;
    period = per;
    clear_mon();
    issue(1'b0, a, d);
    check(busy === 1'b1, "R8 busy after start", busy, 1);
    wait_idle();
    check(pc == 18, "R2 pulse count", pc, 18);
    for (int i = 0; i < 18; i++)
      if (dat_at[i] !== e[i] || en_at[i] !== 1'b0) bad++;
    check(bad == 0, "R2 frame bits", bad, 0);
    check(sen === 1'b1 && busy === 1'b0, "R2 strobe high at end", sen, 1);
    check(viol == 0, "R3 edges", viol, 0);
  endtask

  task automatic t_read(input logic [3:0] a, input logic [7:0] b, input logic [7:0] per);
    logic [17:0] e = hdr(1'b1, a, 8'h00);
    int bad = 0, tail = 0;
    period = per; dev_byte = b;
    clear_mon();
    issue(1'b1, a, 8'h5a);
    wait_idle();
    check(pc == 27, "R4 pulse count", pc, 27);
    for (int i = 0; i < 18; i++)
      if (dat_at[i] !== e[i] || en_at[i] !== 1'b0) bad++;
    if (en_at[18] !== 1'b1) bad++;
    for (int i = 19; i < 27; i++) if (en_at[i] !== 1'b0) bad++;
    check(bad == 0, "R4 header and strobe", bad, 0);
    for (int i = 18; i < 27; i++) if (dat_at[i] !== 1'b0) tail++;
    check(tail == 0, "R5 data low in tail", tail, 0);
    check(rdv_count == 1, "R6 valid count", rdv_count, 1);
    check(rdv_data == b, "R6 read byte", rdv_data, b);
    check(viol == 0, "R3 edges", viol, 0);
  endtask

  task automatic t_period(input logic [7:0] per, input int exp_p);
    t_write(4'h3, 8'h81, per);
    check(per_min == exp_p && per_max == exp_p, "R7 period", per_max, exp_p);
    check(hi_min == exp_p/2 && hi_max == exp_p/2, "R7 high phase", hi_max, exp_p/2);
  endtask

  task automatic t_ignore();
    logic [17:0] e = hdr(1'b0, 4'h9, 8'hc3);
    int bad = 0;
    period = 8'd5;
    clear_mon();
    issue(1'b0, 4'h9, 8'hc3);
    repeat (10) @(negedge clk);
    issue(1'b1, 4'h2, 8'h3c);
    wait_idle();
    repeat (60) @(negedge clk);
    check(pc == 18, "R8 ignored start pulses", pc, 18);
    for (int i = 0; i < 18; i++) if (dat_at[i] !== e[i]) bad++;
    check(bad == 0, "R8 first frame kept", bad, 0);
    check(busy === 1'b0 && rdv_count == 0, "R8 no second frame", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write(4'ha, 8'h96, 8'd4);
    t_write(4'hf, 8'h01, 8'd6);
    t_read(4'h5, 8'hb2, 8'd4);
    t_read(4'h0, 8'h7f, 8'd9);
    t_period(8'd2, 4);
    t_period(8'd7, 7);
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors = errors + 1; checks = checks + 1;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule